// File: doc/BRIEF.md
# Boot Mode Strap and External Interrupt Front End

This block serves a set of shared active-low input pins that do two jobs. While the chip is held in reset, the pins are straps that pick the start-up operating mode. Once reset has been released, the same pins become external interrupt request lines. Every pin passes through a multi-flop synchronizer into the core clock domain. The reset input is also synchronized: it is asserted asynchronously and released on the clock.

A mode register is loaded once, on the clock edge where the synchronized reset first reads inactive. It then holds its value until the next reset. After that edge, each line produces a request through its own trigger and mask settings. A trigger setting of level makes the request follow the synchronized low level. A trigger setting of falling edge arms a sticky pending bit, and a per-line acknowledge pulse clears that bit. A single configuration write port loads all the mask and trigger bits at once.

A separate wake output tells a stopped core to resume whenever the wake line is low. It does not depend on the mask or trigger settings of that line. All pins here are plain control and status signals, so the block has no stream interface and no back-pressure.

Top module: `irqm_ctrl`

## Requirements
- R1: opmode[i] takes the level of pin_n[i] (1 = pin high), sampled on the third rising clock edge after rst_n goes high, provided the pins were stable for at least two cycles before that edge.
- R2: opmode reads all zeros while rst_n is low. After the capture it does not change when the pins change.
- R3: irq is all zeros while rst_n is low and until the mode capture edge.
- R4: A rising edge with cfg_we high loads cfg_mask (bit = 1 enables the line) and cfg_edge (bit = 0 selects level, bit = 1 selects falling edge). Reset leaves every line masked and in level trigger.
- R5: For an enabled line in level trigger, irq[i] is high from the second rising edge after pin_n[i] falls until the second rising edge after it rises. Nothing is latched.
- R6: For a line in falling-edge trigger, a high-to-low pin transition sets a pending bit. An enabled line shows it on irq[i] from the third rising edge after the fall. The bit stays set after the pin returns high.
- R7: ack[i] high at a rising edge clears the pending bit of line i.
- R8: irq[i] is never high while line i is masked. A falling edge that arrives while masked is still recorded, and irq[i] shows it right after the mask bit is enabled.
- R9: wake is high whenever in_stop is high and the synchronized wake-line pin (line 0) is low, whatever the mask and trigger settings. It is low whenever in_stop is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | N_LINES | Shared strap and interrupt pins, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mask | input | N_LINES | Per-line enable bits to load |
| cfg_edge | input | N_LINES | Per-line trigger select to load (1 = falling edge) |
| ack | input | N_LINES | Per-line clear pulse for the pending bit |
| in_stop | input | 1 | Core is in stop or standby |
| opmode | output | N_LINES | Operating mode captured at reset release |
| irq | output | N_LINES | Masked interrupt requests |
| wake | output | 1 | Request to leave stop or standby |

## Verification
If the mode register loads on the wrong edge, or does not hold its value, opmode differs from the strap pattern. This shows one cycle after the capture edge, or a few cycles after the pins change later. If a pending bit is missing or stuck, irq differs from the expected value on the third edge after a pin fall, or on the edge after an acknowledge. Masked edges are checked by enabling the mask later and looking at irq. A wrong path from the wake line or the mask shows on wake or irq two edges after pin 0 changes.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_e;

  localparam int unsigned DEF_LINES  = 4;
  localparam int unsigned DEF_STAGES = 2;
endpackage

// File: rtl/irqm_sync.sv
module irqm_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) stg[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) stg[s] <= stg[s-1];
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irqm_rst_sync.sv
module irqm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/irqm_line.sv
module irqm_line
  import irqm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_b,
  input  logic  run,
  input  logic  pin_s,
  input  logic  mask_en,
  input  trig_e trig,
  input  logic  ack,
  output logic  irq,
  output logic  pend,
  output logic  fall
);
  logic prev;

  always_ff @(posedge clk or negedge rst_b) begin
    if (!rst_b) prev <= 1'b1;
    else        prev <= pin_s;
  end

  assign fall = prev & ~pin_s;

  always_ff @(posedge clk or negedge rst_b) begin
    if (!rst_b)                                  pend <= 1'b0;
    else if (run && trig == TRIG_FALL && fall)   pend <= 1'b1;
    else if (ack)                                pend <= 1'b0;
  end

  logic active;
  always_comb begin
    if (trig == TRIG_FALL) active = pend;
    else                   active = ~pin_s;
  end

  assign irq = run & mask_en & active;
endmodule

// File: rtl/irqm_ctrl.sv
module irqm_ctrl
  import irqm_pkg::*;
#(
  parameter int unsigned N_LINES     = DEF_LINES,
  parameter int unsigned SYNC_STAGES = DEF_STAGES,
  parameter int unsigned WAKE_LINE   = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pin_n,
  input  logic               cfg_we,
  input  logic [N_LINES-1:0] cfg_mask,
  input  logic [N_LINES-1:0] cfg_edge,
  input  logic [N_LINES-1:0] ack,
  input  logic               in_stop,
  output logic [N_LINES-1:0] opmode,
  output logic [N_LINES-1:0] irq,
  output logic               wake
);
  localparam int unsigned MW = N_LINES;

  logic               srst_n;
  logic [N_LINES-1:0] pin_s;
  logic               run_q;
  logic [MW-1:0]      mode_q;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] edge_q;
  logic [N_LINES-1:0] pend;
  logic [N_LINES-1:0] fall;

  irqm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  irqm_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_pins (
    .clk (clk),
    .d   (pin_n),
    .q   (pin_s)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      run_q  <= 1'b0;
      mode_q <= '0;
    end else if (!run_q) begin
      run_q  <= 1'b1;
      mode_q <= pin_s[MW-1:0];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mask_q <= '0;
      edge_q <= '0;
    end else if (cfg_we) begin
      mask_q <= cfg_mask;
      edge_q <= cfg_edge;
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    irqm_line u_line (
      .clk     (clk),
      .rst_b   (srst_n),
      .run     (run_q),
      .pin_s   (pin_s[i]),
      .mask_en (mask_q[i]),
      .trig    (trig_e'(edge_q[i])),
      .ack     (ack[i]),
      .irq     (irq[i]),
      .pend    (pend[i]),
      .fall    (fall[i])
    );
  end

  assign opmode = mode_q;
  assign wake   = in_stop & ~pin_s[WAKE_LINE];
endmodule

// File: rtl/irqm_chk.sv
module irqm_chk #(
  parameter int unsigned N_LINES = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               run_q,
  input logic               in_stop,
  input logic               wake,
  input logic [N_LINES-1:0] opmode,
  input logic [N_LINES-1:0] irq,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] edge_q,
  input logic [N_LINES-1:0] pend,
  input logic [N_LINES-1:0] fall
);
  // R3: no requests while reset is held
  p_quiet_reset_r3: assert property (@(posedge clk)
    !rst_n |-> (irq == '0));

  // R2: mode frozen once captured
  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> $stable(opmode));

  // R8: masked lines never request
  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~mask_q) == '0);

  // R6: an armed falling edge leaves the pending bit set
  p_pend_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ((fall & edge_q) != '0)) |=>
      ((pend & $past(fall & edge_q)) == $past(fall & edge_q)));

  // R9: wake only while stopped
  p_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> in_stop);
endmodule

bind irqm_ctrl irqm_chk #(.N_LINES(N_LINES)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .run_q   (run_q),
  .in_stop (in_stop),
  .wake    (wake),
  .opmode  (opmode),
  .irq     (irq),
  .mask_q  (mask_q),
  .edge_q  (edge_q),
  .pend    (pend),
  .fall    (fall)
);

// File: tb/irqm_ctrl_tb_top.sv
module irqm_ctrl_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_n = '1;
  logic         cfg_we = 1'b0;
  logic [N-1:0] cfg_mask = '0;
  logic [N-1:0] cfg_edge = '0;
  logic [N-1:0] ack = '0;
  logic         in_stop = 1'b0;
  logic [N-1:0] opmode;
  logic [N-1:0] irq;
  logic         wake;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  irqm_ctrl dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_n    (pin_n),
    .cfg_we   (cfg_we),
    .cfg_mask (cfg_mask),
    .cfg_edge (cfg_edge),
    .ack      (ack),
    .in_stop  (in_stop),
    .opmode   (opmode),
    .irq      (irq),
    .wake     (wake)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [N-1:0] m, input logic [N-1:0] e);
    cfg_we = 1'b1; cfg_mask = m; cfg_edge = e;
    edges(1);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset_mode(input logic [N-1:0] pat);
    @(negedge clk);
    rst_n = 1'b0;
    pin_n = pat;
    edges(4);
    chk("R2 opmode zero in reset", opmode, '0);
    chk("R3 irq zero in reset", irq, '0);
    rst_n = 1'b1;
    edges(2);
    chk("R3 irq zero before capture", irq, '0);
    chk("R2 opmode not yet captured", opmode, '0);
    edges(1);
    chk("R1 opmode captured", opmode, pat);
    pin_n = ~pat;
    edges(4);
    chk("R2 opmode held after pins change", opmode, pat);
    pin_n = '1;
    edges(3);
  endtask

  task automatic t_cfg_reset;
    pin_n = 4'b1011;
    edges(3);
    chk("R4 reset leaves lines masked", irq, '0);
    pin_n = '1;
    edges(3);
  endtask

  task automatic t_level;
    write_cfg('1, '0);
    pin_n = 4'b1011;
    edges(1);
    chk("R5 level not yet through sync", irq, '0);
    edges(1);
    chk("R5 level request", irq, 4'b0100);
    pin_n = '1;
    edges(2);
    chk("R5 level request drops", irq, '0);
  endtask

  task automatic t_edge_ack;
    write_cfg('1, '1);
    pin_n = 4'b1101;
    edges(2);
    chk("R6 edge not yet pending", irq, '0);
    edges(1);
    chk("R6 edge pending", irq, 4'b0010);
    pin_n = '1;
    edges(4);
    chk("R6 pending sticky", irq, 4'b0010);
    ack = 4'b0010;
    edges(1);
    ack = '0;
    chk("R7 ack clears", irq, '0);
    edges(2);
    chk("R7 stays clear", irq, '0);
  endtask

  task automatic t_mask;
    write_cfg('0, '1);
    pin_n = 4'b0111;
    edges(4);
    pin_n = '1;
    edges(3);
    chk("R8 masked line silent", irq, '0);
    write_cfg(4'b1000, '1);
    chk("R8 masked edge recorded", irq, 4'b1000);
    ack = 4'b1000;
    edges(1);
    ack = '0;
    chk("R7 ack clears unmasked", irq, '0);
  endtask

  task automatic t_wake;
    write_cfg('0, '1);
    in_stop = 1'b1;
    chk("R9 wake idle", {3'b0, wake}, 4'b0);
    pin_n = 4'b1110;
    edges(2);
    chk("R9 wake raised", {3'b0, wake}, 4'b0001);
    chk("R9 irq stays masked", irq, '0);
    in_stop = 1'b0;
    edges(1);
    chk("R9 wake needs stop", {3'b0, wake}, 4'b0);
    pin_n = '1;
    edges(3);
    ack = '1;
    edges(1);
    ack = '0;
  endtask

  initial begin
    edges(3);
    t_reset_mode(4'b1010);
    t_cfg_reset;
    t_reset_mode(4'b0101);
    t_level;
    t_edge_ack;
    t_mask;
    t_wake;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule